// File: doc/BRIEF.md
# Interrupt Controller Poll and Status Readback Front End

This block is the bus-facing read and polling side of an eight-level interrupt controller. A host reaches it through an active-low chip-select, read and write strobe interface with an 8-bit data bus and a one-bit word address. Address 0 carries a command word when written and returns status when read. Address 1 carries the mask register both ways. The block holds a sticky request register that samples the request inputs. It also holds an in-service register and a mask register, and a priority resolver picks the winning level.

The command word can pick which register later status reads return, and that choice holds until it is changed. The same word can arm a poll, and can switch special mask mode on or off. An armed poll makes the next status read act as an acknowledge. That read returns a byte giving the pending flag and the winning level. If a level wins, the read moves it from the request register into the in-service register. Request sampling is frozen while a poll is armed. A separate end-of-service input retires the highest-priority level in service.

A bus access lasts one clock cycle with the chip select and one strobe held low. Read data is valid during that cycle, and any side effect takes place at the clock edge that ends it.

Top module: `irq_poll_front`

## Requirements
- R1: A synchronous reset clears the request, in-service and mask registers, disarms any poll, leaves special mask mode off and makes status reads return the request register.
- R2: A command write whose bit 1 is 1 sets the status-read choice, with bit 0 = 1 choosing the in-service register and bit 0 = 0 choosing the request register. A command write whose bit 1 is 0 keeps the earlier choice, and repeated status reads keep returning the chosen register.
- R3: A write to address 1 loads the mask register. A read of address 1 returns the mask register, whatever status-read choice is in force.
- R4: A request input seen high on a clock edge sets its request bit, and that bit stays set until the level is acknowledged. The mask never changes the request register as it reads back.
- R5: A command write with bit 2 = 1 arms a poll. The next status read returns bit 7 = 1 if a level wins, bits 2..0 = the winning level number and bits 6..3 = 0. If no level wins, it returns all zeros.
- R6: A poll read with a winner sets that level's in-service bit and clears its request bit. A poll read with no winner changes no register.
- R7: A poll covers one read only. Later status reads return the register chosen under R2, and that choice is the same as before the poll.
- R8: The request register ignores the request inputs from the edge that takes the poll command until the edge that ends the poll read.
- R9: Level 0 has the highest priority and level 7 the lowest. The winner is the highest-priority level whose request bit is set and whose mask bit is clear.
- R10: In normal mode a request at the same priority as the highest-priority in-service level, or lower, cannot win.
- R11: In a command write, bit 6 = 1 with bit 5 = 1 turns special mask mode on, bit 6 = 1 with bit 5 = 0 turns it off, and bit 6 = 0 leaves it unchanged. While the mode is on, only in-service levels whose mask bit is clear block lower levels.
- R12: A one-cycle end-of-service pulse clears the highest-priority in-service bit that is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 1 | Word address: 0 = command/status, 1 = mask |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when no read is in progress |
| irqIn | input | 8 | Request inputs, one per level |
| eoi | input | 1 | End-of-service pulse |

## Verification
The hardest case to reach is a blocking decision that depends on which in-service levels are masked. It needs several levels in service at once, some of them masked, while a lower-priority request waits. The stimulus builds this through a chain of polls that each move one level into service. It then changes the mask and polls under normal mode and under special mask mode. The same waiting request is refused in normal mode and granted in special mask mode. Freezing is tested by pulsing a request input between the poll command and its read, and then reading the request register back.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int DATA_W  = 8;

  // command word bit positions
  localparam int CMD_RIS  = 0;
  localparam int CMD_RR   = 1;
  localparam int CMD_POLL = 2;
  localparam int CMD_SMM  = 5;
  localparam int CMD_ESMM = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IRR,
    SEL_ISR,
    SEL_IMR,
    SEL_POLL
  } rdSel_t;

  typedef struct packed {
    logic   maskWr;
    logic   pollRd;
    logic   freeze;
    logic   smmOn;
    rdSel_t rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] req,
  input  logic [NUM_LVL-1:0] inSvc,
  output logic               winValid,
  output logic [LVL_W-1:0]   winLvl
);
  logic [LVL_W:0] limit;
  logic           limFound;

  // the highest-priority in-service level bounds which requests may win
  always_comb begin
    limit    = (LVL_W+1)'(NUM_LVL);
    limFound = 1'b0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (inSvc[i] && !limFound) begin
        limit    = (LVL_W+1)'(i);
        limFound = 1'b1;
      end
    end
  end

  always_comb begin
    winValid = 1'b0;
    winLvl   = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (req[i] && !winValid && ((LVL_W+1)'(i) < limit)) begin
        winValid = 1'b1;
        winLvl   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output ctlStrobes_t       stb,
  output logic              pollArmed
);
  logic selIsr;
  logic smmQ;
  logic cmdWr;
  logic statRd;
  logic maskRd;

  assign cmdWr  = !csN && !wrN && !addr;
  assign statRd = !csN && !rdN && !addr;
  assign maskRd = !csN && !rdN && addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      selIsr    <= 1'b0;
      smmQ      <= 1'b0;
      pollArmed <= 1'b0;
    end else begin
      if (cmdWr) begin
        if (din[CMD_RR])   selIsr <= din[CMD_RIS];
        if (din[CMD_ESMM]) smmQ   <= din[CMD_SMM];
        pollArmed <= din[CMD_POLL];
      end else if (statRd) begin
        pollArmed <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.maskWr = !csN && !wrN && addr;
    stb.pollRd = statRd && pollArmed;
    stb.freeze = pollArmed || (cmdWr && din[CMD_POLL]);
    stb.smmOn  = smmQ;
    if (maskRd)                      stb.rdSel = SEL_IMR;
    else if (statRd && pollArmed)    stb.rdSel = SEL_POLL;
    else if (statRd && selIsr)       stb.rdSel = SEL_ISR;
    else if (statRd)                 stb.rdSel = SEL_IRR;
    else                             stb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/irq_poll_dp.sv
module irq_poll_dp
  import irq_poll_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobes_t        stb,
  input  logic [DATA_W-1:0]  din,
  input  logic [NUM_LVL-1:0] irqIn,
  input  logic               eoi,
  output logic [DATA_W-1:0]  dout,
  output logic [NUM_LVL-1:0] irrQ,
  output logic [NUM_LVL-1:0] isrQ,
  output logic [NUM_LVL-1:0] imrQ
);
  logic [NUM_LVL-1:0] isrEff;
  logic               winValid;
  logic [LVL_W-1:0]   winLvl;
  logic [NUM_LVL-1:0] ackMask;
  logic [NUM_LVL-1:0] eoiClr;
  logic [DATA_W-1:0]  pollByte;

  assign isrEff = stb.smmOn ? (isrQ & ~imrQ) : isrQ;

  irq_prio_resolver #(.NUM_LVL(NUM_LVL)) u_res (
    .req      (irrQ & ~imrQ),
    .inSvc    (isrEff),
    .winValid (winValid),
    .winLvl   (winLvl)
  );

  assign ackMask = (stb.pollRd && winValid) ? (NUM_LVL'(1) << winLvl) : '0;
  assign eoiClr  = eoi ? (isrQ & ~(isrQ - NUM_LVL'(1))) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irrQ <= '0;
      isrQ <= '0;
      imrQ <= '0;
    end else begin
      if (stb.freeze) irrQ <= irrQ & ~ackMask;
      else            irrQ <= irrQ | irqIn;
      isrQ <= (isrQ & ~eoiClr) | ackMask;
      if (stb.maskWr) imrQ <= din[NUM_LVL-1:0];
    end
  end

  always_comb begin
    pollByte = '0;
    pollByte[DATA_W-1] = winValid;
    pollByte[LVL_W-1:0] = winValid ? winLvl : '0;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_IRR:  dout = DATA_W'(irrQ);
      SEL_ISR:  dout = DATA_W'(isrQ);
      SEL_IMR:  dout = DATA_W'(imrQ);
      SEL_POLL: dout = pollByte;
      default:  dout = '0;
    endcase
  end
endmodule

// File: rtl/irq_poll_front.sv
module irq_poll_front
  import irq_poll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic [NUM_LVL-1:0] irqIn,
  input  logic              eoi
);
  ctlStrobes_t        stb;
  logic               pollArmed;
  logic [NUM_LVL-1:0] irrQ;
  logic [NUM_LVL-1:0] isrQ;
  logic [NUM_LVL-1:0] imrQ;

  irq_poll_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .csN       (csN),
    .rdN       (rdN),
    .wrN       (wrN),
    .addr      (addr),
    .din       (din),
    .stb       (stb),
    .pollArmed (pollArmed)
  );

  irq_poll_dp u_dp (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .din   (din),
    .irqIn (irqIn),
    .eoi   (eoi),
    .dout  (dout),
    .irrQ  (irrQ),
    .isrQ  (isrQ),
    .imrQ  (imrQ)
  );
endmodule

// File: rtl/irq_poll_front_chk.sv
module irq_poll_front_chk
  import irq_poll_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               csN,
  input logic               rdN,
  input logic               addr,
  input logic [DATA_W-1:0]  dout,
  input logic               eoi,
  input logic               pollArmed,
  input logic [NUM_LVL-1:0] irrQ,
  input logic [NUM_LVL-1:0] isrQ,
  input logic [NUM_LVL-1:0] imrQ
);
  logic statRd;
  logic maskRd;
  assign statRd = !csN && !rdN && !addr;
  assign maskRd = !csN && !rdN && addr;

  // R3
  mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
    maskRd |-> dout == DATA_W'(imrQ));

  // R5
  poll_byte_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (statRd && pollArmed) |-> dout[DATA_W-2:LVL_W] == '0);

  // R6
  poll_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (statRd && pollArmed && dout[DATA_W-1] && !eoi) |=>
      ($countones(isrQ) == $past($countones(isrQ)) + 1) &&
      ($countones(irrQ) == $past($countones(irrQ)) - 1));

  // R8
  irr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (pollArmed && !statRd) |=> $stable(irrQ));

  // R7
  poll_single_chk: assert property (@(posedge clk) disable iff (rst)
    (statRd && pollArmed) |=> !pollArmed);

  // R12
  eoi_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && isrQ != '0 && !(statRd && pollArmed)) |=>
      $countones(isrQ) == $past($countones(isrQ)) - 1);
endmodule

bind irq_poll_front irq_poll_front_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .csN       (csN),
  .rdN       (rdN),
  .addr      (addr),
  .dout      (dout),
  .eoi       (eoi),
  .pollArmed (pollArmed),
  .irrQ      (irrQ),
  .isrQ      (isrQ),
  .imrQ      (imrQ)
);

// File: tb/irq_poll_front_test.sv
module irq_poll_front_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic       addr = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [7:0] irqIn = '0;
  logic       eoi = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_poll_front uut (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .din(din), .dout(dout), .irqIn(irqIn), .eoi(eoi)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = a; din = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1; din = '0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] v);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #1 v = dout;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic pulseIrq(input logic [7:0] m);
    @(negedge clk); irqIn = m;
    @(negedge clk); irqIn = '0;
  endtask

  task automatic pulseEoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 idle dout", dout, 8'h00);
    busRead(1'b0, v); check("R1 status after reset", v, 8'h00);
    busRead(1'b1, v); check("R1 mask after reset", v, 8'h00);
  endtask

  task automatic testRequestMask();
    logic [7:0] v;
    pulseIrq(8'h24);
    busRead(1'b0, v); check("R4 sticky requests", v, 8'h24);
    busWrite(1'b1, 8'h04);
    busRead(1'b0, v); check("R4 mask leaves requests", v, 8'h24);
    busRead(1'b1, v); check("R3 mask readback", v, 8'h04);
  endtask

  task automatic testSelect();
    logic [7:0] v;
    busWrite(1'b0, 8'h03);
    busRead(1'b0, v); check("R2 in-service chosen", v, 8'h00);
    busRead(1'b1, v); check("R3 mask under isr choice", v, 8'h04);
    busWrite(1'b0, 8'h00);
    busRead(1'b0, v); check("R2 choice kept", v, 8'h00);
    busWrite(1'b0, 8'h02);
    busRead(1'b0, v); check("R2 request chosen", v, 8'h24);
    busRead(1'b0, v); check("R2 repeated read", v, 8'h24);
  endtask

  task automatic testPollFreeze();
    logic [7:0] v;
    busWrite(1'b0, 8'h04);
    pulseIrq(8'h01);
    busRead(1'b0, v); check("R5 R9 poll byte masked lvl skipped", v, 8'h85);
    busRead(1'b0, v); check("R7 R8 R6 requests after poll", v, 8'h04);
    busWrite(1'b0, 8'h03);
    busRead(1'b0, v); check("R6 level moved in service", v, 8'h20);
  endtask

  task automatic testBlocking();
    logic [7:0] v;
    busWrite(1'b1, 8'h00);
    pulseIrq(8'h80);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R9 R10 higher level wins", v, 8'h82);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R10 lower level blocked", v, 8'h00);
    busRead(1'b0, v); check("R6 R7 no-win poll no change", v, 8'h24);
    busWrite(1'b0, 8'h02);
    busRead(1'b0, v); check("R6 request kept", v, 8'h80);
  endtask

  task automatic testSpecialMask();
    logic [7:0] v;
    busWrite(1'b1, 8'h24);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R10 masked isr blocks in normal mode", v, 8'h00);
    busWrite(1'b0, 8'h60);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R11 special mask grants", v, 8'h87);
    busWrite(1'b0, 8'h03);
    busRead(1'b0, v); check("R11 isr after grant", v, 8'hA4);
  endtask

  task automatic testEoi();
    logic [7:0] v;
    pulseEoi();
    busRead(1'b0, v); check("R12 first retire", v, 8'hA0);
    pulseEoi();
    busRead(1'b0, v); check("R12 second retire", v, 8'h80);
    pulseEoi();
    busRead(1'b0, v); check("R12 last retire", v, 8'h00);
  endtask

  task automatic testModeToggle();
    logic [7:0] v;
    busWrite(1'b1, 8'h00);
    pulseIrq(8'h09);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R9 level 0 first", v, 8'h80);
    busWrite(1'b1, 8'h01);
    busWrite(1'b0, 8'h40);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R11 mode off blocks", v, 8'h00);
    busWrite(1'b0, 8'h20);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R11 no enable keeps off", v, 8'h00);
    busWrite(1'b0, 8'h60);
    busWrite(1'b0, 8'h04);
    busRead(1'b0, v); check("R11 mode on grants", v, 8'h83);
  endtask

  task automatic testResetAgain();
    logic [7:0] v;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    busRead(1'b0, v); check("R1 reset picks requests", v, 8'h00);
    busWrite(1'b0, 8'h03);
    busRead(1'b0, v); check("R1 isr cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testRequestMask();
    testSelect();
    testPollFreeze();
    testBlocking();
    testSpecialMask();
    testEoi();
    testModeToggle();
    testResetAgain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule